// File: doc/BRIEF.md
# Time-Slot Priority Bus Node

This block lets several nodes share one broadcast bus without collisions and without a central arbiter. Time is measured in clock cycles since the bus last carried a transmission. Each node owns a fixed slot number, which is its priority. A node that wants the bus waits until the idle count equals its slot and then starts sending. Lower slot numbers come earlier, so they win. When any node transmits, every node sees the bus as active, restarts its count and stands back until the transmission ends.

Each node runs a four-state controller. The states are idle-busy, skip, wait and send. At the start of every round, the node chooses between skip and wait from its request input. The top level builds four such nodes with slots 1 to 4. It ORs their send flags to form the bus-active line. It also drives one shared idle-cycle counter, which it exposes so the slot timing can be observed.

Top module: `slot_bus_top`

## Requirements
- R1: While reset is high and on the first cycle after it, no node is sending, waiting or skipping, bus_active is 0 and idle_slots is 0.
- R2: In the cycle after any cycle in which bus_active is 1, idle_slots is 0.
- R3: In the cycle after a cycle with bus_active 0, idle_slots is one higher than before. It stops at 99 and holds there.
- R4: A round begins on the first clock edge after reset and on the first edge at which the bus is idle after having been active. At that edge, each node n enters waiting if req[n] is 1 and enters skipping otherwise.
- R5: A node in the busy state (no status bit set) stays busy until the next round begins, whatever its req input does.
- R6: A skipping node returns to busy at the edge after the bus becomes active. Otherwise it stays skipping; a request raised mid-round does not change this.
- R7: A waiting node returns to busy if the bus is active at the clock edge. If the bus is idle and idle_slots equals its slot (node n has slot n+1), it moves to sending at that edge. So in a round where all lower-index nodes skip, node n sends from the (n+2)-th edge of the round on.
- R8: A sending node stays sending while done[n] is 0 and returns to busy at an edge where done[n] is 1.
- R9: bus_active is the OR of the sending bits. At most one bit of sending is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NODES | Per-node transmit request, sampled at round start |
| done | input | NODES | Per-node end of transmission |
| bus_active | output | 1 | OR of all sending bits |
| sending | output | NODES | Node is transmitting |
| waiting | output | NODES | Node is waiting for its slot |
| skipping | output | NODES | Node sits out this round |
| idle_slots | output | CW | Cycles since last bus activity, saturating |

## Verification
A node stuck in the wrong state shows up at the ports within one round. A node that should wait but skips never raises sending at its slot. A node left waiting after the bus goes active can fire a second sender a few cycles later, which breaks the single-sender rule at once. A counter that is off by one moves every node's send edge by one cycle. The bench sweeps every request pattern, both straight after reset and in a following round, and checks the exact edge at which the winner starts.

// File: rtl/slot_bus_pkg.sv
package slot_bus_pkg;

    parameter int unsigned SLOT_LIMIT_DEF = 99;
    parameter int unsigned NODE_COUNT_DEF = 4;

    typedef enum logic [1:0] {
        NS_BUSY = 2'd0,
        NS_SKIP = 2'd1,
        NS_WAIT = 2'd2,
        NS_SEND = 2'd3
    } node_state_e;

    typedef struct packed {
        logic send;
        logic wait_slot;
        logic skip;
    } node_flags_t;

    function automatic int unsigned count_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic node_flags_t flags_of(input node_state_e st);
        node_flags_t f;
        f.send      = (st == NS_SEND);
        f.wait_slot = (st == NS_WAIT);
        f.skip      = (st == NS_SKIP);
        return f;
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import slot_bus_pkg::*;
#(
    parameter int unsigned SLOT_LIMIT = SLOT_LIMIT_DEF,
    localparam int unsigned CW = count_width(SLOT_LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_active,
    output logic [CW-1:0] count,
    output logic          round_start
);
    localparam logic [CW-1:0] LIMIT = CW'(SLOT_LIMIT);

    logic first_q;
    logic prev_active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count         <= '0;
            first_q       <= 1'b1;
            prev_active_q <= 1'b0;
        end else begin
            first_q       <= 1'b0;
            prev_active_q <= bus_active;
            if (bus_active)
                count <= '0;
            else if (count != LIMIT)
                count <= count + 1'b1;
        end
    end

    assign round_start = first_q | (prev_active_q & ~bus_active);

endmodule

// File: rtl/slot_node.sv
module slot_node
    import slot_bus_pkg::*;
#(
    parameter int unsigned SLOT_LIMIT = SLOT_LIMIT_DEF,
    localparam int unsigned CW = count_width(SLOT_LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_active,
    input  logic          round_start,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] prio,
    input  logic          req,
    input  logic          done,
    output node_flags_t   flags
);
    node_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NS_BUSY: if (round_start) state_d = req ? NS_WAIT : NS_SKIP;
            NS_SKIP: if (bus_active)  state_d = NS_BUSY;
            NS_WAIT: begin
                if (bus_active)          state_d = NS_BUSY;
                else if (count == prio)  state_d = NS_SEND;
            end
            NS_SEND: if (done)        state_d = NS_BUSY;
            default:                  state_d = NS_BUSY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= NS_BUSY;
        else     state_q <= state_d;
    end

    assign flags = flags_of(state_q);

endmodule

// File: rtl/slot_bus_top.sv
module slot_bus_top
    import slot_bus_pkg::*;
#(
    parameter int unsigned NODES      = NODE_COUNT_DEF,
    parameter int unsigned SLOT_LIMIT = SLOT_LIMIT_DEF,
    localparam int unsigned CW = count_width(SLOT_LIMIT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NODES-1:0] req,
    input  logic [NODES-1:0] done,
    output logic             bus_active,
    output logic [NODES-1:0] sending,
    output logic [NODES-1:0] waiting,
    output logic [NODES-1:0] skipping,
    output logic [CW-1:0]    idle_slots
);
    logic round_start;

    slot_timer #(.SLOT_LIMIT(SLOT_LIMIT)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .bus_active  (bus_active),
        .count       (idle_slots),
        .round_start (round_start)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam logic [CW-1:0] SLOT = CW'(n + 1);
        node_flags_t fl;

        slot_node #(.SLOT_LIMIT(SLOT_LIMIT)) u_node (
            .clk         (clk),
            .rst         (rst),
            .bus_active  (bus_active),
            .round_start (round_start),
            .count       (idle_slots),
            .prio        (SLOT),
            .req         (req[n]),
            .done        (done[n]),
            .flags       (fl)
        );

        assign sending[n]  = fl.send;
        assign waiting[n]  = fl.wait_slot;
        assign skipping[n] = fl.skip;
    end

    assign bus_active = |sending;

endmodule

// File: rtl/slot_bus_checker.sv
module slot_bus_checker
    import slot_bus_pkg::*;
#(
    parameter int unsigned NODES      = NODE_COUNT_DEF,
    parameter int unsigned SLOT_LIMIT = SLOT_LIMIT_DEF,
    localparam int unsigned CW = count_width(SLOT_LIMIT)
) (
    input logic             clk,
    input logic             rst,
    input logic [NODES-1:0] done,
    input logic             bus_active,
    input logic [NODES-1:0] sending,
    input logic [NODES-1:0] waiting,
    input logic [NODES-1:0] skipping,
    input logic [CW-1:0]    idle_slots
);
    localparam logic [CW-1:0] LIMIT = CW'(SLOT_LIMIT);

    AST_ONE_SENDER: assert property (@(posedge clk) disable iff (rst)
        $countones(sending) <= 1);                                          // R9

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bus_active |=> (idle_slots == '0));                                 // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!bus_active && idle_slots != LIMIT) |=>
            (idle_slots == CW'($past(idle_slots) + 1'b1)));                 // R3

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        (!bus_active && idle_slots == LIMIT) |=> (idle_slots == LIMIT));    // R3

    for (genvar n = 0; n < NODES; n++) begin : g_chk
        AST_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
            $countones({sending[n], waiting[n], skipping[n]}) <= 1);        // R4

        AST_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sending[n] && !done[n]) |=> sending[n]);                       // R8

        AST_SEND_END: assert property (@(posedge clk) disable iff (rst)
            (sending[n] && done[n]) |=> !sending[n]);                       // R8

        AST_SKIP_LEAVE: assert property (@(posedge clk) disable iff (rst)
            (skipping[n] && bus_active) |=>
                !(skipping[n] || waiting[n] || sending[n]));                // R6

        AST_WAIT_FIRE: assert property (@(posedge clk) disable iff (rst)
            (waiting[n] && !bus_active && idle_slots == CW'(n + 1)) |=>
                sending[n]);                                                // R7
    end

endmodule

bind slot_bus_top slot_bus_checker #(
    .NODES      (NODES),
    .SLOT_LIMIT (SLOT_LIMIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .bus_active (bus_active),
    .sending    (sending),
    .waiting    (waiting),
    .skipping   (skipping),
    .idle_slots (idle_slots)
);

// File: tb/sim_slot_bus_top.sv
`timescale 1ns/1ps
module sim_slot_bus_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req;
    logic [3:0] done;
    logic       bus_active;
    logic [3:0] sending, waiting, skipping;
    logic [6:0] idle_slots;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    slot_bus_top u0 (
        .clk(clk), .rst(rst), .req(req), .done(done),
        .bus_active(bus_active), .sending(sending), .waiting(waiting),
        .skipping(skipping), .idle_slots(idle_slots)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int lowest(input logic [3:0] p);
        for (int i = 0; i < 4; i++) if (p[i]) return i;
        return -1;
    endfunction

    // Called just after the edge that begins a round.
    task automatic play(input logic [3:0] pat);
        logic [3:0] npat = ~pat;
        int w = lowest(pat);
        chk("R4 waiting at round start", 32'(waiting), 32'(pat));
        chk("R4 skipping at round start", 32'(skipping), 32'(npat));
        chk("R3 count after first idle edge", 32'(idle_slots), 32'd1);
        if (w < 0) return;
        for (int k = 0; k < w + 1; k++) begin
            chk("R9 no sender before slot", 32'(sending), 32'd0);
            tick();
        end
        chk("R7 winner sends at its slot", 32'(sending), 32'(4'(1 << w)));
        chk("R9 bus_active follows sender", 32'(bus_active), 32'd1);
        chk("R3 count at send edge", 32'(idle_slots), 32'(w + 2));
        tick();
        chk("R7 waiting nodes fall to busy", 32'(waiting), 32'd0);
        chk("R6 skipping nodes fall to busy", 32'(skipping), 32'd0);
        chk("R2 count cleared by activity", 32'(idle_slots), 32'd0);
        tick();
        tick();
        chk("R8 sender holds without done", 32'(sending), 32'(4'(1 << w)));
        chk("R5 busy nodes ignore req", 32'(waiting), 32'd0);
        done = 4'(1 << w);
        tick();
        done = '0;
        chk("R8 done ends sending", 32'(sending), 32'd0);
        chk("R9 bus idle after done", 32'(bus_active), 32'd0);
    endtask

    initial begin
        rst = 1'b1; req = '0; done = '0;
        for (int p = 0; p < 16; p++) begin
            logic [3:0] pat  = 4'(p);
            logic [3:0] pat2 = pat ^ 4'b1010;
            rst = 1'b1;
            req = pat;
            tick();
            tick();
            chk("R1 reset sending", 32'(sending), 32'd0);
            chk("R1 reset status", 32'({waiting, skipping}), 32'd0);
            chk("R1 reset count", 32'(idle_slots), 32'd0);
            rst = 1'b0;
            tick();
            play(pat);
            if (pat == 4'd0) begin
                tick(); tick(); tick(); tick();
                req = 4'b0001;
                for (int k = 0; k < 5; k++) tick();
                chk("R6 late request ignored", 32'(skipping), 32'hF);
                chk("R6 late request no wait", 32'(waiting), 32'd0);
                for (int k = 0; k < 100; k++) tick();
                chk("R3 count saturates", 32'(idle_slots), 32'd99);
                tick();
                chk("R3 count holds at limit", 32'(idle_slots), 32'd99);
                chk("R9 no sender in empty round", 32'(sending), 32'd0);
            end else begin
                req = pat2;
                tick();
                play(pat2);
            end
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule